// File: doc/BRIEF.md
# Multi-core job dispatcher

This block hands pending jobs to a pool of processing cores. Software loads a 32-bit queue word that holds up to four one-byte job entries, packed from the least significant byte upward. Each entry names a session and how many cores the job wants. The dispatcher looks only at the entry in the lowest byte. When that job can run, it starts the required number of cores in a single cycle and pops the queue.

Each session has a control word and a schedulable flag. The control word holds a per-core mask of cores the session may not use, and a cap on how many cores may run the session at once. A job runs only when four things hold: scheduling is enabled, its session is schedulable, enough allowed cores are idle, and the cap would still be met after the start. The block keeps a 4-bit session tag for every core and drives it out as the core's status. That tag is also the session ID that goes with each core's start pulse. A core goes back to idle when it pulses done.

Software stops scheduling by clearing the enable register. It must then poll the enable readback until it reads 0, which happens only after every started core has reported done.

Top module: `job_dispatch`

## Requirements
- R1: After reset the queue reads 0x0F0F0F0F and every core status reads 15. The enable readback is 0 and no start pulse is driven.
- R2: The job in queue byte 0 carries its session in bits [3:0] and its core count minus one in bits [7:4]. When it is issued, exactly that many cores see a start pulse lasting one cycle, on the clock edge after the decision. From that edge on, each started core's status reads the session.
- R3: A queue byte 0 equal to 0x0F is an empty slot and is never dispatched.
- R4: The queue register is written at address 0x01. Only byte 0 is considered, so later entries wait behind a blocked head. On an issue the queue shifts down one byte and 0x0F fills byte 3. A queue write on the same edge as an issue takes precedence over the shift.
- R5: Session s has a control word at address 0x40+s, and bit i of that word forbids core i for the session. A job waits until the number of idle cores allowed for its session is at least its count.
- R6: Control word bits [11:8] of a session cap how many cores may run that session at once, with 0 meaning no cap. A job is issued only if the cores already running the session plus the job's count do not exceed a nonzero cap.
- R7: Session s has a schedulable flag at address 0x80+s, bit 0. No job for a session is issued while its flag is 0, and a session ID of 8 or above is never issued.
- R8: The enable register is written at address 0x00, bit 0. Nothing is issued while it is 0. The enable readback is 1 while the register is 1 or any core is busy.
- R9: A done pulse on a busy core makes its status read 15 from the next clock edge. A done pulse on an idle core has no effect.
- R10: An issued job takes the lowest-indexed idle cores that its session allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| core_done | input | NCORE | Per-core done pulse |
| core_start | output | NCORE | Per-core start pulse |
| core_sess | output | 4*NCORE | Per-core session tag, 15 when idle (core i at bits 4i+3:4i) |
| queue_rd | output | 32 | Current queue contents |
| enable_rd | output | 1 | Enable readback |

## Verification
A register write lands on the clock edge where it is presented. The dispatch decision uses the register state from before that edge, so a job written at edge E can start at edge E+1 at the earliest. Its start pulses, status tags and popped queue all appear together just after E+1. A done pulse returns a core to 15 on the edge where it is sampled, and the enable readback follows the registers with no extra delay. The bench drives inputs on the falling edge and steps a reference model once per rising edge. It compares every output 1 ns after each rising edge, so each result is checked in the cycle it becomes due and in no other.

// File: rtl/job_dispatch.sv
module job_dispatch #(
  parameter int NCORE = 4,
  parameter int NSESS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [NCORE-1:0]   core_done,
  output logic [NCORE-1:0]   core_start,
  output logic [4*NCORE-1:0] core_sess,
  output logic [31:0]        queue_rd,
  output logic               enable_rd
);
  localparam logic [3:0] IDLE  = 4'hF;
  localparam logic [7:0] EMPTY = 8'h0F;
  localparam logic [7:0] A_EN  = 8'h00;
  localparam logic [7:0] A_Q   = 8'h01;
  localparam logic [7:0] A_CTL = 8'h40;
  localparam logic [7:0] A_SCH = 8'h80;

  logic             en_q;
  logic [31:0]      queue_q;
  logic [11:0]      ctrl_q  [NSESS];
  logic [NSESS-1:0] sched_q;
  logic [3:0]       sess_q  [NCORE];
  logic [NCORE-1:0] start_q;

  logic [3:0]       hs;
  logic [4:0]       need;
  logic [11:0]      sel_ctrl;
  logic             sel_sched;
  logic [NCORE-1:0] idle, allow, pick;
  logic [4:0]       avail, run, taken;
  logic [5:0]       total;
  logic             cap_ok, issue, q_wr, busy_any;

  assign hs   = queue_q[3:0];
  assign need = {1'b0, queue_q[7:4]} + 5'd1;
  assign q_wr = wr_en && (wr_addr == A_Q);

  always_comb begin
    sel_ctrl  = '0;
    sel_sched = 1'b0;
    for (int s = 0; s < NSESS; s++)
      if (hs == 4'(s)) begin
        sel_ctrl  = ctrl_q[s];
        sel_sched = sched_q[s];
      end
  end

  always_comb begin
    avail = '0;
    run   = '0;
    for (int i = 0; i < NCORE; i++) begin
      idle[i]  = (sess_q[i] == IDLE);
      allow[i] = idle[i] && !sel_ctrl[i];
      if (allow[i]) avail = avail + 5'd1;
      if (sess_q[i] == hs) run = run + 5'd1;
    end
  end

  assign total    = {1'b0, run} + {1'b0, need};
  assign cap_ok   = (sel_ctrl[11:8] == 4'd0) || (total <= {2'b00, sel_ctrl[11:8]});
  assign issue    = en_q && (queue_q[7:0] != EMPTY) && sel_sched && (avail >= need) && cap_ok;
  assign busy_any = ~&idle;

  always_comb begin
    pick  = '0;
    taken = '0;
    for (int i = 0; i < NCORE; i++)
      if (issue && allow[i] && (taken < need)) begin
        pick[i] = 1'b1;
        taken   = taken + 5'd1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      queue_q <= {4{EMPTY}};
      sched_q <= '0;
      start_q <= '0;
      for (int s = 0; s < NSESS; s++) ctrl_q[s] <= '0;
      for (int i = 0; i < NCORE; i++) sess_q[i] <= IDLE;
    end else begin
      if (wr_en && wr_addr == A_EN) en_q <= wr_data[0];
      if (q_wr)       queue_q <= wr_data;
      else if (issue) queue_q <= {EMPTY, queue_q[31:8]};
      for (int s = 0; s < NSESS; s++) begin
        if (wr_en && wr_addr == A_CTL + 8'(s)) ctrl_q[s]  <= wr_data[11:0];
        if (wr_en && wr_addr == A_SCH + 8'(s)) sched_q[s] <= wr_data[0];
      end
      for (int i = 0; i < NCORE; i++)
        if (core_done[i] && !idle[i]) sess_q[i] <= IDLE;
        else if (pick[i])             sess_q[i] <= hs;
      start_q <= pick;
    end
  end

  assign core_start = start_q;
  assign queue_rd   = queue_q;
  assign enable_rd  = en_q | busy_any;

  genvar g;
  generate
    for (g = 0; g < NCORE; g++) begin : g_core
      assign core_sess[4*g +: 4] = sess_q[g];

      assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_start[g] |-> ($past(sess_q[g]) == IDLE) && (sess_q[g] == $past(queue_q[3:0])));

      assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_start[g] |=> !core_start[g]);

      assert_disallow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_start[g] |-> !$past(sel_ctrl[g]));

      assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done[g] && sess_q[g] != IDLE) |=> (sess_q[g] == IDLE) && !core_start[g]);
    end
  endgenerate

  assert_start_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_start) |-> $countones(core_start) == int'($past(queue_q[7:4])) + 1);

  assert_start_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_start) |-> $past(en_q) && $past(sel_sched));

  assert_queue_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|core_start) && !$past(q_wr)) |-> queue_q[31:24] == EMPTY);

  assert_no_empty_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_start) |-> $past(queue_q[7:0]) != EMPTY);
endmodule

// File: tb/test_job_dispatch.sv
`timescale 1ns/1ps
module test_job_dispatch;
  localparam int NC = 4;
  localparam int NS = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NC-1:0] core_done = '0;
  logic [NC-1:0] core_start;
  logic [4*NC-1:0] core_sess;
  logic [31:0] queue_rd;
  logic enable_rd;

  int checks = 0, errors = 0;
  bit finished = 0;

  bit [31:0] mq;
  bit [3:0]  ms  [NC];
  bit [11:0] mc  [NS];
  bit        mch [NS];
  bit        men;
  bit [NC-1:0] mst;

  always #2.5 clk = ~clk;

  job_dispatch #(.NCORE(NC), .NSESS(NS)) i_job_dispatch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .core_done(core_done), .core_start(core_start), .core_sess(core_sess),
    .queue_rd(queue_rd), .enable_rd(enable_rd));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    mq = 32'h0F0F0F0F; men = 0; mst = '0;
    for (int i = 0; i < NC; i++) ms[i] = 4'hF;
    for (int s = 0; s < NS; s++) begin mc[s] = '0; mch[s] = 0; end
  endfunction

  function automatic void model(bit w, bit [7:0] a, bit [31:0] d, bit [NC-1:0] dn);
    bit [3:0] s = mq[3:0];
    int need = int'(mq[7:4]) + 1;
    bit [11:0] c = '0;
    bit sch = 0, go;
    int avail = 0, run = 0, taken = 0;
    bit [NC-1:0] pick = '0;
    if (s < NS) begin c = mc[s]; sch = mch[s]; end
    for (int i = 0; i < NC; i++) begin
      if (ms[i] == 4'hF && !c[i]) avail++;
      if (ms[i] == s) run++;
    end
    go = men && mq[7:0] != 8'h0F && sch && avail >= need &&
         (c[11:8] == 0 || run + need <= int'(c[11:8]));
    if (go)
      for (int i = 0; i < NC; i++)
        if (ms[i] == 4'hF && !c[i] && taken < need) begin pick[i] = 1; taken++; end
    for (int i = 0; i < NC; i++)
      if (dn[i] && ms[i] != 4'hF) ms[i] = 4'hF;
      else if (pick[i]) ms[i] = s;
    mst = pick;
    if (w && a == 8'h01) mq = d;
    else if (go) mq = {8'h0F, mq[31:8]};
    if (w && a == 8'h00) men = d[0];
    if (w && a >= 8'h40 && a < 8'h40 + NS) mc[a - 8'h40] = d[11:0];
    if (w && a >= 8'h80 && a < 8'h80 + NS) mch[a - 8'h80] = d[0];
  endfunction

  function automatic bit [4*NC-1:0] exp_sess();
    bit [4*NC-1:0] v;
    for (int i = 0; i < NC; i++) v[4*i +: 4] = ms[i];
    return v;
  endfunction

  function automatic bit exp_en();
    bit b = men;
    for (int i = 0; i < NC; i++) if (ms[i] != 4'hF) b = 1;
    return b;
  endfunction

  task automatic step(input bit w, input bit [7:0] a, input bit [31:0] d, input bit [NC-1:0] dn);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; core_done = dn;
    @(posedge clk);
    model(w, a, d, dn);
    #1;
    chk("R4 queue", queue_rd, mq);
    chk("R2 status", 32'(core_sess), 32'(exp_sess()));
    chk("R10 start", 32'(core_start), 32'(mst));
    chk("R8 enable", 32'(enable_rd), 32'(exp_en()));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 8'h00, 0, '0);
  endtask

  task automatic flush();
    step(1, 8'h00, 0, '0);
    step(1, 8'h01, 32'h0F0F0F0F, '1);
    step(0, 8'h00, 0, '1);
  endtask

  function automatic bit [31:0] rand_queue();
    bit [31:0] q = 32'h0F0F0F0F;
    int n = $urandom % 5;
    for (int k = 0; k < n; k++)
      q[8*k +: 8] = {4'($urandom % 4), 4'($urandom % 10)};
    return q;
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] r;
    r = $urandom(32'd20240);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.5;
    chk("R1 reset queue", queue_rd, 32'h0F0F0F0F);
    chk("R1 reset status", 32'(core_sess), 32'h0000FFFF);
    chk("R1 reset enable", 32'(enable_rd), 0);
    chk("R1 reset start", 32'(core_start), 0);

    step(1, 8'h82, 1, '0);
    step(1, 8'h01, 32'h0F0F0F12, '0);
    idle(2);
    chk("R8 disabled no start", 32'(core_start), 0);
    chk("R8 disabled queue held", queue_rd, 32'h0F0F0F12);
    step(1, 8'h00, 1, '0);
    step(0, 8'h00, 0, '0);
    chk("R2 two cores started", 32'(core_start), 32'h3);
    chk("R10 lowest cores", 32'(core_sess), 32'h0000FF22);
    chk("R4 popped", queue_rd, 32'h0F0F0F0F);
    step(0, 8'h00, 0, '0);
    chk("R2 pulse ends", 32'(core_start), 0);
    idle(2);
    chk("R3 empty slot", 32'(core_start), 0);

    step(1, 8'h43, 32'h004, '0);
    step(1, 8'h83, 1, '0);
    step(1, 8'h01, 32'h0F0F2213, '0);
    idle(2);
    chk("R5 blocked by mask", 32'(core_start), 0);
    chk("R4 head blocks rest", queue_rd, 32'h0F0F2213);
    step(0, 8'h00, 0, 4'b0001);
    step(0, 8'h00, 0, '0);
    chk("R5 masked core skipped", 32'(core_start), 32'h9);
    chk("R5 status", 32'(core_sess), 32'h00003F23);
    step(0, 8'h00, 0, 4'b0100);
    chk("R9 done on idle core", 32'(core_sess), 32'h00003F23);
    idle(2);
    flush();

    step(1, 8'h00, 1, '0);
    step(1, 8'h44, 32'h100, '0);
    step(1, 8'h84, 1, '0);
    step(1, 8'h01, 32'h0F0F0F14, '0);
    idle(3);
    chk("R6 cap blocks", 32'(core_start), 0);
    step(1, 8'h01, 32'h0F0F0404, '0);
    idle(3);
    chk("R6 one under cap", 32'(core_sess), 32'h0000FFF4);
    chk("R6 second waits", queue_rd, 32'h0F0F0F04);
    step(0, 8'h00, 0, 4'b0001);
    idle(2);
    chk("R6 second after release", 32'(core_sess), 32'h0000FFF4);

    step(1, 8'h01, 32'h0F0F0F05, '0);
    idle(3);
    chk("R7 unschedulable", queue_rd, 32'h0F0F0F05);
    step(1, 8'h85, 1, '0);
    idle(2);
    chk("R7 after flag", queue_rd, 32'h0F0F0F0F);

    step(1, 8'h00, 0, '0);
    idle(1);
    chk("R8 drain readback", 32'(enable_rd), 1);
    step(0, 8'h00, 0, '1);
    chk("R8 stopped readback", 32'(enable_rd), 0);
    chk("R9 all idle", 32'(core_sess), 32'h0000FFFF);

    for (int n = 0; n < 3000; n++) begin
      int k = $urandom % 16;
      bit [NC-1:0] dn = ($urandom % 3 == 0) ? NC'($urandom) : '0;
      if (k < 3)       step(1, 8'h01, rand_queue(), dn);
      else if (k == 3) step(1, 8'h40 + 8'($urandom % NS), {20'h0, 4'($urandom % 4), 4'h0, 4'($urandom & 32'h3)}, dn);
      else if (k == 4) step(1, 8'h80 + 8'($urandom % NS), 32'($urandom % 4 != 0), dn);
      else if (k == 5) step(1, 8'h00, 32'($urandom % 5 != 0), dn);
      else             step(0, 8'h00, 0, dn);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule